// File: doc/BRIEF.md
# Secured Configuration Fuse Store

This block holds the complete configuration bit vector of a small programmable logic device: the AND-array row bits, the per-macrocell polarity and input/output-select bits, the product-term-disable bits, the two global mode bits and a 64-bit user signature. Every field is decoded from the flat bit vector and driven out continuously, so the logic fabric next to the block can use the fields directly. Bits are loaded one at a time. An addressed write stores the bit at `addr_i`. A serial write stores the bit at an internal pointer that advances after each accepted write.

Readback is addressed and takes one cycle. A one-way security bit guards the device. Once it is set, reads of functional fuses return zero and raise a blocked flag. The signature bits stay readable whatever the security state. The only way to clear the security bit is a bulk erase, which zeroes every fuse and the security bit in one cycle. A write aimed outside the map is dropped and flagged.

Top module: `fuse_store_top`

## Requirements
- R1: After the active-low reset every fuse and the security bit are 0, and all outputs and flags are 0.
- R2: An addressed write (`wr_i`) stores `wdata_i` at `addr_i`. Addresses 0..2047 appear as `and_array_o[addr]`; cell c row r column k sits at c*256 + r*32 + k.
- R3: Address 2048+i drives `pol_o[i]` and address 2120+i drives `ac1_o[i]`, for i = 0..7.
- R4: Signature address 2056+k drives `sig_o[63-k]` for k = 0..63, so the lowest signature address is the most significant bit.
- R5: Address 2128+k drives `ptd_o[k]` for k = 0..63; address 2192 drives `syn_o` and address 2193 drives `ac0_o`.
- R6: A serial write (`shift_i` without `wr_i`) stores `wdata_i` at the pointer and then advances it by one. An accepted addressed write sets the pointer to `addr_i`+1. Reset and erase set the pointer to 0. `wr_i` has priority over `shift_i`.
- R7: A write whose target is above 2193, whether addressed or serial, changes no fuse and does not move the pointer, and `wr_err_o` is high for exactly the next cycle.
- R8: A read (`rd_i`) loads `rdata_o` in the next cycle with the fuse value that held before that edge. A read of an address above 2193 returns 0 with `rd_blocked_o` low. Both outputs hold until the next read.
- R9: While secured, a read of any non-signature address returns 0 and sets `rd_blocked_o`.
- R10: Signature addresses 2056..2119 read back their stored values, with `rd_blocked_o` low, whether or not the device is secured.
- R11: `sec_prog_i` sets `secured_o` from the next cycle. The bit then stays set through writes and reads until an erase.
- R12: `erase_i` zeroes every fuse, the security bit and the pointer in one cycle. It overrides a write or `sec_prog_i` given in the same cycle and raises no write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Fuse address for addressed write and read |
| wdata_i | input | 1 | Bit to store |
| wr_i | input | 1 | Addressed write strobe |
| shift_i | input | 1 | Serial write strobe (pointer target) |
| rd_i | input | 1 | Read strobe |
| erase_i | input | 1 | Bulk erase strobe |
| sec_prog_i | input | 1 | Security-bit program strobe |
| rdata_o | output | 1 | Read result |
| rd_blocked_o | output | 1 | Last read was refused by security |
| wr_err_o | output | 1 | Previous cycle's write targeted an unmapped address |
| secured_o | output | 1 | Security bit |
| and_array_o | output | 2048 | AND-array fuse bits |
| pol_o | output | 8 | Per-cell output polarity bits |
| ac1_o | output | 8 | Per-cell I/O select bits |
| ptd_o | output | 64 | Product-term-disable bits |
| syn_o | output | 1 | Global mode bit SYN |
| ac0_o | output | 1 | Global mode bit AC0 |
| sig_o | output | 64 | User signature, byte 7 in the top bits |

## Verification
Directed writes land on the first and last address of every region, which catches an off-by-one at any region boundary and a reversed signature byte order. A serial burst runs across the last mapped address to show where the pointer stops and where the error flag appears. Reads of array, signature and unmapped addresses are repeated before securing, after securing and after erase, which separates blocking by region from blocking by security state. A long seeded random mix of writes, serial writes, reads, security programming and rare erases is then compared against a bench model of the whole map. Simultaneous-strobe cases check the priority of erase over write and over security programming.

// File: rtl/fuse_store_pkg.sv
`timescale 1ns/1ps
package fuse_store_pkg;
  typedef enum logic [2:0] {
    RG_ARRAY, RG_POL, RG_SIG, RG_AC1, RG_PTD, RG_GLB, RG_NONE
  } fuse_region_e;
endpackage

// File: rtl/fuse_addr_decode.sv
`timescale 1ns/1ps
module fuse_addr_decode
  import fuse_store_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int POL_BASE = 2048,
  parameter int SIG_BASE = 2056,
  parameter int AC1_BASE = 2120,
  parameter int PTD_BASE = 2128,
  parameter int GLB_BASE = 2192,
  parameter int TOTAL    = 2194
) (
  input  logic [ADDR_W-1:0] addr_i,
  output fuse_region_e      region_o
);
  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(POL_BASE);
  localparam logic [ADDR_W-1:0] A_SIG = ADDR_W'(SIG_BASE);
  localparam logic [ADDR_W-1:0] A_AC1 = ADDR_W'(AC1_BASE);
  localparam logic [ADDR_W-1:0] A_PTD = ADDR_W'(PTD_BASE);
  localparam logic [ADDR_W-1:0] A_GLB = ADDR_W'(GLB_BASE);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(TOTAL);

  always_comb begin
    if      (addr_i < A_POL) region_o = RG_ARRAY;
    else if (addr_i < A_SIG) region_o = RG_POL;
    else if (addr_i < A_AC1) region_o = RG_SIG;
    else if (addr_i < A_PTD) region_o = RG_AC1;
    else if (addr_i < A_GLB) region_o = RG_PTD;
    else if (addr_i < A_END) region_o = RG_GLB;
    else                     region_o = RG_NONE;
  end
endmodule

// File: rtl/fuse_write_ctrl.sv
`timescale 1ns/1ps
module fuse_write_ctrl #(
  parameter int ADDR_W = 12,
  parameter int TOTAL  = 2194
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              shift_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tgt_valid_i,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              we_o,
  output logic              wr_err_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              req;

  assign req        = (wr_i | shift_i) & ~erase_i;
  assign tgt_addr_o = wr_i ? addr_i : ptr_q;
  assign we_o       = req & tgt_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      wr_err_o <= 1'b0;
    end else begin
      wr_err_o <= req & ~tgt_valid_i;
      if (erase_i)   ptr_q <= '0;
      else if (we_o) ptr_q <= tgt_addr_o + ADDR_W'(1);
    end
  end

  AST_PTR_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= ADDR_W'(TOTAL)); // R6
  AST_ERASE_PTR_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (ptr_q == '0) && !wr_err_o); // R12
endmodule

// File: rtl/fuse_cells.sv
`timescale 1ns/1ps
module fuse_cells #(
  parameter int ADDR_W = 12,
  parameter int TOTAL  = 2194
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic              erase_i,
  input  logic              sec_set_i,
  output logic [TOTAL-1:0]  fuses_o,
  output logic              secured_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuses_o   <= '0;
      secured_o <= 1'b0;
    end else if (erase_i) begin
      fuses_o   <= '0;
      secured_o <= 1'b0;
    end else begin
      if (we_i)      fuses_o[waddr_i] <= wdata_i;
      if (sec_set_i) secured_o <= 1'b1;
    end
  end

  AST_ERASE_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (fuses_o == '0) && !secured_o); // R12
  AST_SEC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secured_o && !erase_i |=> secured_o); // R11
  AST_SEC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_set_i && !erase_i |=> secured_o); // R11
endmodule

// File: rtl/fuse_read_guard.sv
`timescale 1ns/1ps
module fuse_read_guard
  import fuse_store_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TOTAL  = 2194
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  fuse_region_e      region_i,
  input  logic              secured_i,
  input  logic [TOTAL-1:0]  fuses_i,
  output logic              rdata_o,
  output logic              rd_blocked_o
);
  logic mapped, deny;

  assign mapped = (region_i != RG_NONE);
  // signature stays open regardless of security
  assign deny   = mapped & secured_i & (region_i != RG_SIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= 1'b0;
      rd_blocked_o <= 1'b0;
    end else if (rd_i) begin
      rd_blocked_o <= deny;
      rdata_o      <= (mapped && !deny) ? fuses_i[addr_i] : 1'b0;
    end
  end

  AST_BLOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_blocked_o |-> !rdata_o); // R9
  AST_SIG_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (region_i == RG_SIG) |=> !rd_blocked_o); // R10
  AST_UNSECURED_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !secured_i |=> !rd_blocked_o); // R8
endmodule

// File: rtl/fuse_store_top.sv
`timescale 1ns/1ps
module fuse_store_top
  import fuse_store_pkg::*;
#(
  parameter int N_CELLS  = 8,
  parameter int ROWS     = 8,
  parameter int COLS     = 32,
  parameter int SIG_BITS = 64,
  localparam int ARRAY_BITS = N_CELLS * ROWS * COLS,
  localparam int PTD_BITS   = N_CELLS * ROWS,
  localparam int POL_BASE   = ARRAY_BITS,
  localparam int SIG_BASE   = POL_BASE + N_CELLS,
  localparam int AC1_BASE   = SIG_BASE + SIG_BITS,
  localparam int PTD_BASE   = AC1_BASE + N_CELLS,
  localparam int GLB_BASE   = PTD_BASE + PTD_BITS,
  localparam int TOTAL      = GLB_BASE + 2,
  localparam int ADDR_W     = $clog2(TOTAL + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wdata_i,
  input  logic                  wr_i,
  input  logic                  shift_i,
  input  logic                  rd_i,
  input  logic                  erase_i,
  input  logic                  sec_prog_i,
  output logic                  rdata_o,
  output logic                  rd_blocked_o,
  output logic                  wr_err_o,
  output logic                  secured_o,
  output logic [ARRAY_BITS-1:0] and_array_o,
  output logic [N_CELLS-1:0]    pol_o,
  output logic [N_CELLS-1:0]    ac1_o,
  output logic [PTD_BITS-1:0]   ptd_o,
  output logic                  syn_o,
  output logic                  ac0_o,
  output logic [SIG_BITS-1:0]   sig_o
);
  fuse_region_e      rd_region, wr_region;
  logic [ADDR_W-1:0] tgt_addr;
  logic              we;
  logic [TOTAL-1:0]  fuses;

  fuse_addr_decode #(
    .ADDR_W(ADDR_W), .POL_BASE(POL_BASE), .SIG_BASE(SIG_BASE),
    .AC1_BASE(AC1_BASE), .PTD_BASE(PTD_BASE), .GLB_BASE(GLB_BASE), .TOTAL(TOTAL)
  ) u_rd_dec (.addr_i(addr_i), .region_o(rd_region));

  fuse_addr_decode #(
    .ADDR_W(ADDR_W), .POL_BASE(POL_BASE), .SIG_BASE(SIG_BASE),
    .AC1_BASE(AC1_BASE), .PTD_BASE(PTD_BASE), .GLB_BASE(GLB_BASE), .TOTAL(TOTAL)
  ) u_wr_dec (.addr_i(tgt_addr), .region_o(wr_region));

  fuse_write_ctrl #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) u_wctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .shift_i(shift_i),
    .erase_i(erase_i), .addr_i(addr_i), .tgt_valid_i(wr_region != RG_NONE),
    .tgt_addr_o(tgt_addr), .we_o(we), .wr_err_o(wr_err_o)
  );

  fuse_cells #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) u_cells (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .waddr_i(tgt_addr),
    .wdata_i(wdata_i), .erase_i(erase_i), .sec_set_i(sec_prog_i),
    .fuses_o(fuses), .secured_o(secured_o)
  );

  fuse_read_guard #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) u_rguard (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
    .region_i(rd_region), .secured_i(secured_o), .fuses_i(fuses),
    .rdata_o(rdata_o), .rd_blocked_o(rd_blocked_o)
  );

  assign and_array_o = fuses[ARRAY_BITS-1:0];
  assign pol_o       = fuses[POL_BASE +: N_CELLS];
  assign ac1_o       = fuses[AC1_BASE +: N_CELLS];
  assign ptd_o       = fuses[PTD_BASE +: PTD_BITS];
  assign syn_o       = fuses[GLB_BASE];
  assign ac0_o       = fuses[GLB_BASE + 1];

  // lowest signature address is the MSB of the top byte
  for (genvar k = 0; k < SIG_BITS; k++) begin : g_sig
    assign sig_o[SIG_BITS-1-k] = fuses[SIG_BASE + k];
  end

  AST_BAD_WRITE_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $stable(fuses)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o && !wr_i && !shift_i |=> !wr_err_o); // R7
endmodule

// File: tb/fuse_store_top_bench.sv
`timescale 1ns/1ps
module fuse_store_top_bench;
  localparam int TOTAL = 2194, ARRAY_BITS = 2048, POL_BASE = 2048, SIG_BASE = 2056;
  localparam int AC1_BASE = 2120, PTD_BASE = 2128, GLB_BASE = 2192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic wdata = 1'b0, wr = 1'b0, sh = 1'b0, rd = 1'b0, er = 1'b0, sp = 1'b0;
  logic rdata, blk, werr, sec, syn, ac0;
  logic [2047:0] and_a;
  logic [7:0] pol, ac1;
  logic [63:0] ptd, sig;

  int checks = 0, fails = 0;
  logic [TOTAL-1:0] m_f = '0;
  bit m_sec = 0, m_err = 0, m_rd = 0, m_blk = 0;
  int m_ptr = 0;

  always #2.5 clk = ~clk;

  fuse_store_top u_fuse_store_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .shift_i(sh), .rd_i(rd), .erase_i(er), .sec_prog_i(sp), .rdata_o(rdata),
    .rd_blocked_o(blk), .wr_err_o(werr), .secured_o(sec), .and_array_o(and_a),
    .pol_o(pol), .ac1_o(ac1), .ptd_o(ptd), .syn_o(syn), .ac0_o(ac0), .sig_o(sig)
  );

  task automatic chk(bit ok, string req, string what, logic [2047:0] act, logic [2047:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_sig();
    logic [63:0] s;
    for (int k = 0; k < 64; k++) s[63-k] = m_f[SIG_BASE+k];
    return s;
  endfunction

  task automatic check_all(string ctx);
    chk(and_a == m_f[ARRAY_BITS-1:0], "R2", {ctx, " and_array"}, and_a, m_f[ARRAY_BITS-1:0]);
    chk(pol == m_f[POL_BASE +: 8], "R3", {ctx, " pol"}, pol, m_f[POL_BASE +: 8]);
    chk(ac1 == m_f[AC1_BASE +: 8], "R3", {ctx, " ac1"}, ac1, m_f[AC1_BASE +: 8]);
    chk(sig == exp_sig(), "R4", {ctx, " sig"}, sig, exp_sig());
    chk(ptd == m_f[PTD_BASE +: 64], "R5", {ctx, " ptd"}, ptd, m_f[PTD_BASE +: 64]);
    chk({syn, ac0} == {m_f[GLB_BASE], m_f[GLB_BASE+1]}, "R5", {ctx, " syn/ac0"},
        {syn, ac0}, {m_f[GLB_BASE], m_f[GLB_BASE+1]});
    chk(sec == m_sec, "R11", {ctx, " secured"}, sec, m_sec);
    chk(werr == m_err, "R7", {ctx, " wr_err"}, werr, m_err);
    chk(rdata == m_rd, "R8", {ctx, " rdata"}, rdata, m_rd);
    chk(blk == m_blk, "R9", {ctx, " rd_blocked"}, blk, m_blk);
  endtask

  // drive one cycle of strobes, update model, check after the edge
  task automatic op(bit w, bit s, bit p, bit e, bit r, int a, bit d, string ctx);
    int t;
    @(negedge clk);
    wr = w; sh = s; sp = p; er = e; rd = r; addr = 12'(a); wdata = d;
    @(posedge clk);
    if (r) begin
      if (a < TOTAL) begin
        m_blk = m_sec && !(a >= SIG_BASE && a < AC1_BASE);
        m_rd  = m_blk ? 1'b0 : m_f[a];
      end else begin
        m_blk = 0; m_rd = 0;
      end
    end
    if (e) begin
      m_f = '0; m_sec = 0; m_ptr = 0; m_err = 0;
    end else begin
      if (p) m_sec = 1;
      m_err = 0;
      if (w || s) begin
        t = w ? a : m_ptr;
        if (t < TOTAL) begin m_f[t] = d; m_ptr = t + 1; end
        else m_err = 1;
      end
    end
    @(negedge clk);
    wr = 0; sh = 0; sp = 0; er = 0; rd = 0;
    check_all(ctx);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    op(1,0,0,0,0, 0, 1, "R2 addr0");
    op(1,0,0,0,0, 2047, 1, "R2 addr2047");
    op(1,0,0,0,0, 256+32+5, 1, "R2 cell1 row1 col5");
    op(1,0,0,0,0, 2048, 1, "R3 pol0");
    op(1,0,0,0,0, 2055, 1, "R3 pol7");
    op(1,0,0,0,0, 2120, 1, "R3 ac1_0");
    op(1,0,0,0,0, 2127, 1, "R3 ac1_7");
    op(1,0,0,0,0, 2056, 1, "R4 sig msb");
    op(1,0,0,0,0, 2119, 1, "R4 sig lsb");
    op(1,0,0,0,0, 2128, 1, "R5 ptd0");
    op(1,0,0,0,0, 2191, 1, "R5 ptd63");
    op(1,0,0,0,0, 2192, 1, "R5 syn");
    op(1,0,0,0,0, 2193, 1, "R5 ac0");
    op(1,0,0,0,0, 2194, 1, "R7 addr2194");
    op(1,0,0,0,0, 4095, 1, "R7 addr4095");
    op(1,0,0,0,0, 2190, 1, "R6 set pointer");
    op(0,1,0,0,0, 0, 0, "R6 serial 2191");
    op(0,1,0,0,0, 0, 0, "R6 serial 2192");
    op(0,1,0,0,0, 0, 1, "R6 serial 2193");
    op(0,1,0,0,0, 0, 1, "R7 serial past end");
    op(0,1,0,0,0, 0, 1, "R7 serial past end again");
    op(1,1,0,0,0, 300, 1, "R6 wr priority");
    op(0,1,0,0,0, 0, 1, "R6 serial after 300");
    op(0,0,0,0,1, 2193, 0, "R8 read ac0");
    op(0,0,0,0,1, 5, 0, "R8 read zero");
    op(0,0,0,0,1, 3000, 0, "R8 read unmapped");
    op(0,0,1,0,0, 0, 0, "R11 program security");
    op(0,0,0,0,1, 0, 0, "R9 blocked array");
    op(0,0,0,0,1, 2193, 0, "R9 blocked global");
    op(0,0,0,0,1, 2056, 0, "R10 sig msb secured");
    op(0,0,0,0,1, 2119, 0, "R10 sig lsb secured");
    op(0,0,0,0,1, 2057, 0, "R10 sig zero secured");
    op(1,0,0,0,0, 10, 1, "R11 write keeps secure");
    op(0,0,0,0,1, 10, 0, "R9 blocked after write");
    op(1,0,1,1,0, 20, 1, "R12 erase beats write+sec");
    op(0,1,0,0,0, 0, 1, "R12 pointer home");
    op(0,0,0,0,1, 0, 0, "R12 readable after erase");
    op(1,0,0,0,0, 4000, 1, "R7 before erase");
    op(0,0,0,1,0, 0, 0, "R12 erase clears err");

    for (int i = 0; i < 800; i++) begin
      int k, a;
      k = $urandom % 32;
      a = ($urandom % 4 == 0) ? (SIG_BASE + $urandom % 140) : ($urandom % (TOTAL + 40));
      if (k == 0)       op(0,0,0,1,0, a, 0, "R12 rand erase");
      else if (k < 3)   op(0,0,1,0,$urandom%2, a, 0, "R11 rand sec");
      else if (k < 12)  op(1,0,0,0,$urandom%2, a, $urandom%2, "R2 rand wr");
      else if (k < 18)  op(0,1,0,0,$urandom%2, a, $urandom%2, "R6 rand shift");
      else              op(0,0,0,0,1, a, 0, "R10 rand read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule